// File: doc/BRIEF.md
# Even-Lane Widening SIMD Multiplier

This block multiplies two 128-bit vectors of signed integers, using only the lanes at even positions. Lane 0 is the leftmost, most significant lane of each vector. For every even lane index, the lane of the first source is multiplied by the lane of the second source at the same index. The full-precision product, twice the source lane width, is written over the even/odd lane pair of the result that begins at that index. Lanes at odd positions of either source are never read.

A two-bit size code picks the source lane width: byte (0), halfword (1) or word (2). These give halfword, word and doubleword products. Code 3 is not a valid size. It produces an error pulse and leaves the result unchanged.

The unit is a fixed two-stage pipeline. A one-cycle `start` pulse presents an operation. The matching `done` (or `err`) pulse appears two cycles later. There is no back-pressure: the unit takes a new operation on every cycle in which `start` is high and never stalls. The caller must capture `result` in the cycle `done` is high. Between `done` pulses, `result` keeps its last value.

Top module: `even_lane_multiplier`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `done` and `err` are 0 and `result` is all zeros.
- R2: With size code 0, for each k in 0..7, the signed byte at bits [127-16k -: 8] of each source is multiplied, and the 16-bit product is placed at result bits [127-16k -: 16].
- R3: With size code 1, for each k in 0..3, the signed halfword at bits [127-32k -: 16] of each source is multiplied, and the 32-bit product is placed at result bits [127-32k -: 32].
- R4: With size code 2, for each k in 0..1, the signed word at bits [127-64k -: 32] of each source is multiplied, and the 64-bit product is placed at result bits [127-64k -: 64].
- R5: Source lanes are two's-complement values and products keep full precision, with no truncation or saturation. For example, byte 0x80 times 0x80 gives 0x4000, and word 0xFFFFFFFF times 0x00000001 gives 0xFFFFFFFFFFFFFFFF.
- R6: Changing any odd-position source lane does not change the result.
- R7: `done` is high for exactly one cycle, two clock cycles after the cycle in which `start` was high with a valid size code. Starts in consecutive cycles each yield their own `done` pulse, in order.
- R8: A start with size code 3 gives a one-cycle `err` pulse two cycles later. It gives no `done` pulse and does not change `result`.
- R9: `result` changes only in a cycle where `done` is high, and it holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe; sources and size are sampled when high |
| size | input | 2 | Source lane width: 0 byte, 1 halfword, 2 word, 3 invalid |
| src_a | input | 128 | First source vector, lane 0 in the top bits |
| src_b | input | 128 | Second source vector, lane 0 in the top bits |
| result | output | 128 | Widened products, updated with `done` |
| done | output | 1 | One-cycle pulse: `result` holds a new product set |
| err | output | 1 | One-cycle pulse: the operation had an invalid size code |

## Verification
The assertions check the pipeline timing on every cycle:
- A valid start is accepted into the first stage.
- An invalid start raises only the error path.
- `done` follows a valid first-stage entry, and `done` and `err` are never high together.
- `result` stays stable whenever `done` is low.

The numeric content of the products can only be shown by the bench scenarios. This covers lane placement for each size, sign handling at the extreme values, and the blindness to odd lanes.

// File: rtl/elm_pkg.sv
package elm_pkg;
  typedef enum logic [1:0] {
    LANE_BYTE = 2'd0,
    LANE_HALF = 2'd1,
    LANE_WORD = 2'd2,
    LANE_BAD  = 2'd3
  } lane_size_e;

  function automatic logic size_is_valid(input logic [1:0] code);
    return code != LANE_BAD;
  endfunction
endpackage

// File: rtl/elm_lane_select.sv
module elm_lane_select
  import elm_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BASE_W = 8,
  localparam int MAXW  = 4 * BASE_W,
  localparam int NL    = VEC_W / (2 * BASE_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               size,
  input  logic [VEC_W-1:0]         src_a,
  input  logic [VEC_W-1:0]         src_b,
  output logic                     s1_valid,
  output logic                     s1_bad,
  output lane_size_e               s1_size,
  output logic [NL-1:0][MAXW-1:0]  op_a,
  output logic [NL-1:0][MAXW-1:0]  op_b
);
  logic [NL-1:0][MAXW-1:0] ext_a, ext_b;
  logic size_ok;

  assign size_ok = size_is_valid(size);

  // Lane k takes the upper (even) element of pair chunk k, sign-extended.
  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic [MAXW-1:0] a_b, b_b, a_h, b_h, a_w, b_w;
    localparam int TB = VEC_W - 1 - 2 * BASE_W * k;
    assign a_b = {{(MAXW-BASE_W){src_a[TB]}}, src_a[TB -: BASE_W]};
    assign b_b = {{(MAXW-BASE_W){src_b[TB]}}, src_b[TB -: BASE_W]};
    if (k < NL / 2) begin : g_half
      localparam int TH = VEC_W - 1 - 4 * BASE_W * k;
      assign a_h = {{(MAXW-2*BASE_W){src_a[TH]}}, src_a[TH -: 2*BASE_W]};
      assign b_h = {{(MAXW-2*BASE_W){src_b[TH]}}, src_b[TH -: 2*BASE_W]};
    end else begin : g_no_half
      assign a_h = '0;
      assign b_h = '0;
    end
    if (k < NL / 4) begin : g_word
      localparam int TW = VEC_W - 1 - 8 * BASE_W * k;
      assign a_w = src_a[TW -: MAXW];
      assign b_w = src_b[TW -: MAXW];
    end else begin : g_no_word
      assign a_w = '0;
      assign b_w = '0;
    end
    always_comb begin
      unique case (lane_size_e'(size))
        LANE_HALF: begin ext_a[k] = a_h; ext_b[k] = b_h; end
        LANE_WORD: begin ext_a[k] = a_w; ext_b[k] = b_w; end
        default:   begin ext_a[k] = a_b; ext_b[k] = b_b; end
      endcase
    end
  end

  // Odd-position lanes are intentionally not read by every mode.
  logic unused_src;
  assign unused_src = ^{src_a, src_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_bad   <= 1'b0;
      s1_size  <= LANE_BYTE;
      op_a     <= '0;
      op_b     <= '0;
    end else begin
      s1_valid <= start && size_ok;
      s1_bad   <= start && !size_ok;
      if (start && size_ok) begin
        s1_size <= lane_size_e'(size);
        op_a    <= ext_a;
        op_b    <= ext_b;
      end
    end
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && size != 2'd3) |=> (s1_valid && !s1_bad));
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && size == 2'd3) |=> (s1_bad && !s1_valid));
endmodule

// File: rtl/elm_product_place.sv
module elm_product_place
  import elm_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BASE_W = 8,
  localparam int MAXW  = 4 * BASE_W,
  localparam int NL    = VEC_W / (2 * BASE_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic                     s1_bad,
  input  lane_size_e               s1_size,
  input  logic [NL-1:0][MAXW-1:0]  op_a,
  input  logic [NL-1:0][MAXW-1:0]  op_b,
  output logic [VEC_W-1:0]         result,
  output logic                     done,
  output logic                     err
);
  logic [VEC_W-1:0] pl_b, pl_h, pl_w, placed;

  for (genvar k = 0; k < NL; k++) begin : g_mul
    logic signed [2*MAXW-1:0] prod;
    assign prod = $signed(op_a[k]) * $signed(op_b[k]);
    assign pl_b[VEC_W-1-2*BASE_W*k -: 2*BASE_W] = prod[2*BASE_W-1:0];
    if (k < NL / 4) begin : g_w
      assign pl_w[VEC_W-1-8*BASE_W*k -: 8*BASE_W] = prod;
    end
    if (k < NL / 2) begin : g_h
      assign pl_h[VEC_W-1-4*BASE_W*k -: 4*BASE_W] = prod[4*BASE_W-1:0];
    end
    if (k >= NL / 4) begin : g_hi_unused
      logic unused_hi;
      assign unused_hi = ^prod[2*MAXW-1:4*BASE_W];
    end
  end

  always_comb begin
    unique case (s1_size)
      LANE_HALF: placed = pl_h;
      LANE_WORD: placed = pl_w;
      default:   placed = pl_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= s1_valid;
      err  <= s1_bad;
      if (s1_valid) result <= placed;
    end
  end

  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s1_valid));
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: rtl/even_lane_multiplier.sv
module even_lane_multiplier
  import elm_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BASE_W = 8,
  localparam int MAXW  = 4 * BASE_W,
  localparam int NL    = VEC_W / (2 * BASE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       size,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result,
  output logic             done,
  output logic             err
);
  logic                    s1_valid, s1_bad;
  lane_size_e              s1_size;
  logic [NL-1:0][MAXW-1:0] op_a, op_b;

  elm_lane_select #(.VEC_W(VEC_W), .BASE_W(BASE_W)) u_select (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size),
    .src_a(src_a), .src_b(src_b),
    .s1_valid(s1_valid), .s1_bad(s1_bad), .s1_size(s1_size),
    .op_a(op_a), .op_b(op_b)
  );

  elm_product_place #(.VEC_W(VEC_W), .BASE_W(BASE_W)) u_place (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_bad(s1_bad),
    .s1_size(s1_size), .op_a(op_a), .op_b(op_b),
    .result(result), .done(done), .err(err)
  );

  p_err_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(s1_bad));
endmodule

// File: tb/even_lane_multiplier_bench.sv
module even_lane_multiplier_bench;
  logic clk = 1'b0;
  logic rst_n, start;
  logic [1:0] size;
  logic [127:0] src_a, src_b, result;
  logic done, err;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  even_lane_multiplier u_even_lane_multiplier (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size),
    .src_a(src_a), .src_b(src_b), .result(result), .done(done), .err(err)
  );

  localparam int NV = 6;
  localparam logic [127:0] TA [NV] = '{
    128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
    128'h80FF_7F01_FE00_1234_8080_7F7F_FF01_0203,
    128'h0001_0002_8000_1111_7FFF_2222_FFFF_3333,
    128'hFFFE_0000_1234_0000_8000_0000_0003_0000,
    128'h0000_0005_ABCD_EF01_FFFF_FFFF_9999_9999,
    128'h8000_0000_1111_1111_7FFF_FFFF_0000_0000};
  localparam logic [127:0] TB [NV] = '{
    128'h1011_1213_1415_1617_1819_1A1B_1C1D_1E1F,
    128'h80AA_FF55_7F00_C0DE_0180_817F_0101_FF02,
    128'h7FFF_0000_8000_0000_7FFF_0000_0003_0000,
    128'hFFFF_5555_FFFF_6666_8000_7777_FFFD_8888,
    128'h0000_0007_0123_4567_0000_0001_1234_5678,
    128'h8000_0000_2222_2222_8000_0000_0000_0000};
  localparam logic [1:0] TC [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2};

  function automatic logic [127:0] model(input logic [127:0] a, b, input logic [1:0] c);
    logic [127:0] r = '0;
    case (c)
      2'd0: for (int k = 0; k < 8; k++) begin
        logic signed [7:0] x, y; logic signed [15:0] p;
        x = a[127-16*k -: 8]; y = b[127-16*k -: 8]; p = x * y;
        r[127-16*k -: 16] = p;
      end
      2'd1: for (int k = 0; k < 4; k++) begin
        logic signed [15:0] x, y; logic signed [31:0] p;
        x = a[127-32*k -: 16]; y = b[127-32*k -: 16]; p = x * y;
        r[127-32*k -: 32] = p;
      end
      default: for (int k = 0; k < 2; k++) begin
        logic signed [31:0] x, y; logic signed [63:0] p;
        x = a[127-64*k -: 32]; y = b[127-64*k -: 32]; p = x * y;
        r[127-64*k -: 64] = p;
      end
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Issue one op; returns done seen one cycle later, then outputs two cycles later.
  task automatic run_one(input logic [127:0] a, b, input logic [1:0] c,
                         output logic early_done, output logic [127:0] r,
                         output logic d, output logic e);
    @(negedge clk); start = 1; src_a = a; src_b = b; size = c;
    @(negedge clk); start = 0; src_a = '1; src_b = '1; early_done = done;
    @(negedge clk); r = result; d = done; e = err;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ed, d, e;
    logic [127:0] r, r2, prev;
    rst_n = 0; start = 0; size = 0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", {127'd0, done}, 128'd0);
    check("R1 err in reset", {127'd0, err}, 128'd0);
    check("R1 result in reset", result, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 result after release", result, 128'd0);

    for (int i = 0; i < NV; i++) begin
      run_one(TA[i], TB[i], TC[i], ed, r, d, e);
      check(TC[i] == 0 ? "R2 byte products" : TC[i] == 1 ? "R3 halfword products" : "R4 word products",
            r, model(TA[i], TB[i], TC[i]));
      check("R7 done at latency 2", {127'd0, d}, 128'd1);
    end

    // R5 sign extremes with hand-computed values
    run_one({8{16'h8080}}, {8{16'h8080}}, 2'd0, ed, r, d, e);
    check("R5 byte -128*-128", r, {8{16'h4000}});
    run_one({8{16'hFF00}}, {8{16'h7F00}}, 2'd0, ed, r, d, e);
    check("R5 byte -1*127", r, {8{16'hFF81}});
    run_one({32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 32'h0},
            {32'h8000_0000, 32'h0, 32'h0000_0001, 32'h0}, 2'd2, ed, r, d, e);
    check("R5 word extremes", r, {64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF});
    run_one({4{32'h8000_0000}}, {4{32'h7FFF_0000}}, 2'd1, ed, r, d, e);
    check("R5 halfword -32768*32767", r, {4{32'hC000_8000}});

    // R6 odd lanes ignored (halfword: odd halfwords are low halves of each word)
    run_one(128'h1234_0000_8001_0000_7FFF_0000_FFFF_0000,
            128'h0003_0000_0002_0000_FFFF_0000_7000_0000, 2'd1, ed, r, d, e);
    run_one(128'h1234_FFFF_8001_5A5A_7FFF_1234_FFFF_8000,
            128'h0003_AAAA_0002_FFFF_FFFF_0001_7000_7FFF, 2'd1, ed, r2, d, e);
    check("R6 odd halfwords no effect", r2, r);
    run_one(128'h7F00_8000_0100_FF00_7F00_8000_0100_FF00,
            128'h7F00_7F00_FF00_FF00_0200_0300_0400_0500, 2'd0, ed, r, d, e);
    run_one(128'h7F11_8022_0133_FF44_7F55_8066_0177_FF88,
            128'h7FEE_7FDD_FFCC_FFBB_02AA_0399_0488_0577, 2'd0, ed, r2, d, e);
    check("R6 odd bytes no effect", r2, r);

    // R7 latency and single-cycle pulse
    run_one(TA[0], TB[0], 2'd0, ed, r, d, e);
    check("R7 no done at latency 1", {127'd0, ed}, 128'd0);
    @(negedge clk);
    check("R7 done lasts one cycle", {127'd0, done}, 128'd0);

    // R7 back-to-back starts
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R7 streaming done", {127'd0, done}, 128'd1);
        check("R7 streaming result order", result, model(TA[i-2], TB[i-2], TC[i-2]));
      end
      if (i < 3) begin
        start = 1; src_a = TA[i]; src_b = TB[i]; size = TC[i];
      end else start = 0;
    end

    // R8 invalid size
    @(negedge clk); prev = result;
    run_one(TA[1], TB[1], 2'd3, ed, r, d, e);
    check("R8 err pulse", {127'd0, e}, 128'd1);
    check("R8 no done", {127'd0, d}, 128'd0);
    check("R8 result unchanged", r, prev);
    @(negedge clk);
    check("R8 err one cycle", {127'd0, err}, 128'd0);

    // R9 hold between pulses
    prev = result;
    repeat (3) @(negedge clk);
    check("R9 result held", result, prev);

    finish_run();
  end
endmodule